// File: doc/BRIEF.md
# Branch, Call and Stack Control Unit

This block decides where a word-addressed processor goes next and how its stack pointer moves. Each cycle it takes the current instruction's operation type, the present instruction pointer (IP) and stack pointer (SP), the zero and sign flags, a signed relative location, an operand value and the instruction's length in words. From these it produces the next IP, the next SP and at most one memory request for the stack. Decode and arithmetic sit outside. The surrounding pipeline registers the next IP and SP itself.

Relative targets are measured from the start of the current instruction and count whole 32-bit words. An offset of zero therefore re-executes the same instruction. The stack grows toward lower addresses. A push stores at SP and then lowers SP. A pop raises SP first and then reads there. Calls and software interrupts push the address of the following instruction. A return loads IP from the word that the pop reads. A halt operation freezes IP and SP and sets a sticky halted output that only reset clears.

Top module: `flow_ctl_unit`

## Requirements
- R1: After reset, `halted` is 0 and the block follows the operation on its inputs.
- R2: Type 0x50 always jumps: `next_ip` = `cur_ip` + sign-extended `rel_loc` (word units), so an offset of 0 gives `cur_ip` and negative offsets move backward.
- R3: Types 0x51, 0x52, 0x53 and 0x54 jump when, respectively, Z is 1, Z is 0, S is 1 and S is 0. Otherwise `next_ip` = `cur_ip` + `instr_len`.
- R4: Type 0x55 jumps when S or Z is 1. Type 0x56 jumps only when S and Z are both 0.
- R5: Any type that is not a jump, stack, call, return or halt operation gives `next_ip` = `cur_ip` + `instr_len`, leaves SP unchanged and raises no memory request.
- R6: Types 0x60 and 0x61 (push) request a write of `opnd_val` at `cur_sp` and give `next_sp` = `cur_sp` − 1.
- R7: Type 0x62 (pop) requests a read at `cur_sp` + 1 and gives `next_sp` = `cur_sp` + 1. SP wraps modulo 2^32.
- R8: Type 0x70 (call) writes `cur_ip` + `instr_len` at `cur_sp`, gives `next_sp` = `cur_sp` − 1 and `next_ip` = `cur_ip` + sign-extended `rel_loc`.
- R9: Type 0x72 (software interrupt) pushes `cur_ip` + `instr_len` as a call does and gives `next_ip` = `opnd_val`.
- R10: Type 0x71 (return) requests a read at `cur_sp` + 1, gives `next_sp` = `cur_sp` + 1 and `next_ip` = `mem_rdata`.
- R11: Type 0xEE (halt) gives `next_ip` = `cur_ip` with SP unchanged and no request. From the next clock edge `halted` is 1 until reset. While halted, every operation yields `next_ip` = `cur_ip`, `next_sp` = `cur_sp` and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_type | input | 8 | Operation type code of the current instruction |
| cur_ip | input | 32 | Address of the current instruction |
| cur_sp | input | 32 | Current stack pointer |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| rel_loc | input | 24 | Signed relative location in words |
| opnd_val | input | 32 | Value to push, or absolute target for a software interrupt |
| instr_len | input | 2 | Length of the current instruction in words |
| mem_rdata | input | 32 | Data returned for the stack read |
| next_ip | output | 32 | Instruction pointer for the next cycle |
| next_sp | output | 32 | Stack pointer for the next cycle |
| mem_req | output | 1 | Stack memory access requested |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Stack access address |
| mem_wdata | output | 32 | Stack write data |
| halted | output | 1 | Sticky halt indicator |

## Verification
Every conditional type is driven under all four combinations of Z and S. This separates each flag-pair condition from its neighbours and catches a swapped or inverted flag. Jumps use positive, zero, negative and most-negative offsets, which show whether sign extension and the current-instruction base are correct. Stack operations run at ordinary SP values and at the wrap points 0 and all-ones, which expose pre-versus-post ordering of the pointer update. A halt is followed by jumps and pushes, then a reset, which shows whether the freeze holds and whether it clears.

// File: rtl/flow_pkg.sv
package flow_pkg;

   typedef enum logic [7:0] {
      OP_JMP   = 8'h50,
      OP_JZ    = 8'h51,
      OP_JNZ   = 8'h52,
      OP_JS    = 8'h53,
      OP_JNS   = 8'h54,
      OP_JLE   = 8'h55,
      OP_JGT   = 8'h56,
      OP_PUSHI = 8'h60,
      OP_PUSHR = 8'h61,
      OP_POP   = 8'h62,
      OP_CALL  = 8'h70,
      OP_RET   = 8'h71,
      OP_SWI   = 8'h72,
      OP_HALT  = 8'hEE
   } flow_op_e;

   typedef enum logic [1:0] {
      STK_NONE = 2'd0,
      STK_PUSH = 2'd1,
      STK_POP  = 2'd2
   } stk_act_e;

   typedef enum logic [2:0] {
      TGT_SEQ  = 3'd0,
      TGT_REL  = 3'd1,
      TGT_ABS  = 3'd2,
      TGT_MEM  = 3'd3,
      TGT_HOLD = 3'd4
   } tgt_sel_e;

   typedef struct packed {
      stk_act_e stk;
      logic     push_ret;
      tgt_sel_e tgt;
      logic     is_cond;
   } flow_ctl_t;

endpackage

// File: rtl/flow_op_class.sv
module flow_op_class
   import flow_pkg::*;
(
   input  logic [7:0] op_type,
   input  logic       halted,
   output flow_ctl_t  ctl
);

   always_comb begin
      ctl = '{stk: STK_NONE, push_ret: 1'b0, tgt: TGT_SEQ, is_cond: 1'b0};
      if (halted) begin
         ctl.tgt = TGT_HOLD;
      end else begin
         case (op_type)
            OP_JMP, OP_JZ, OP_JNZ, OP_JS, OP_JNS, OP_JLE, OP_JGT: begin
               ctl.tgt     = TGT_REL;
               ctl.is_cond = 1'b1;
            end
            OP_PUSHI, OP_PUSHR: ctl.stk = STK_PUSH;
            OP_POP:             ctl.stk = STK_POP;
            OP_CALL: begin
               ctl.stk      = STK_PUSH;
               ctl.push_ret = 1'b1;
               ctl.tgt      = TGT_REL;
            end
            OP_SWI: begin
               ctl.stk      = STK_PUSH;
               ctl.push_ret = 1'b1;
               ctl.tgt      = TGT_ABS;
            end
            OP_RET: begin
               ctl.stk = STK_POP;
               ctl.tgt = TGT_MEM;
            end
            OP_HALT: ctl.tgt = TGT_HOLD;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/flow_cond_eval.sv
module flow_cond_eval #(
   parameter int COND_STYLE = 0
) (
   input  logic [2:0] cond_code,
   input  logic       flag_z,
   input  logic       flag_s,
   output logic       taken
);

   if (COND_STYLE != 0 && COND_STYLE != 1) begin : g_bad_style
      $error("flow_cond_eval: COND_STYLE must be 0 or 1");
   end

   if (COND_STYLE == 0) begin : g_case
      always_comb begin
         case (cond_code)
            3'd0:    taken = 1'b1;
            3'd1:    taken = flag_z;
            3'd2:    taken = !flag_z;
            3'd3:    taken = flag_s;
            3'd4:    taken = !flag_s;
            3'd5:    taken = flag_s | flag_z;
            3'd6:    taken = !(flag_s | flag_z);
            default: taken = 1'b0;
         endcase
      end
   end else begin : g_table
      // Each entry is a truth column indexed by {S,Z}.
      localparam logic [3:0] TRUTH [0:7] = '{
         4'b1111, 4'b1010, 4'b0101, 4'b1100,
         4'b0011, 4'b1110, 4'b0001, 4'b0000
      };
      logic [1:0] idx;
      assign idx   = {flag_s, flag_z};
      assign taken = TRUTH[cond_code][idx];
   end

endmodule

// File: rtl/flow_ip_sel.sv
module flow_ip_sel
   import flow_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LOC_W  = 24,
   parameter int LEN_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tgt_sel_e          tgt,
   input  logic              taken,
   input  logic [ADDR_W-1:0] cur_ip,
   input  logic [LOC_W-1:0]  rel_loc,
   input  logic [LEN_W-1:0]  instr_len,
   input  logic [ADDR_W-1:0] abs_target,
   input  logic [ADDR_W-1:0] mem_target,
   output logic [ADDR_W-1:0] ret_ip,
   output logic [ADDR_W-1:0] next_ip
);

   logic [ADDR_W-1:0] rel_ext;

   if (LOC_W < ADDR_W) begin : g_sext
      assign rel_ext = {{(ADDR_W-LOC_W){rel_loc[LOC_W-1]}}, rel_loc};
   end else begin : g_full
      assign rel_ext = rel_loc;
   end

   assign ret_ip = cur_ip + ADDR_W'(instr_len);

   always_comb begin
      case (tgt)
         TGT_REL:  next_ip = taken ? (cur_ip + rel_ext) : ret_ip;
         TGT_ABS:  next_ip = abs_target;
         TGT_MEM:  next_ip = mem_target;
         TGT_HOLD: next_ip = cur_ip;
         default:  next_ip = ret_ip;
      endcase
   end

   // R2: a taken relative transfer with offset zero stays on the same word
   a_r2_zero_loop: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt == TGT_REL && taken && rel_loc == '0) |-> next_ip == cur_ip);

   // R8: the return address handed to the stack is past the current instruction
   a_r8_ret_ahead: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_len != '0) |-> ret_ip != cur_ip);

endmodule

// File: rtl/flow_stack_seq.sv
module flow_stack_seq
   import flow_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  stk_act_e          act,
   input  logic [ADDR_W-1:0] cur_sp,
   input  logic [DATA_W-1:0] push_data,
   output logic [ADDR_W-1:0] next_sp,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata
);

   logic [ADDR_W-1:0] sp_up;
   logic [ADDR_W-1:0] sp_dn;

   assign sp_up = cur_sp + ADDR_W'(1);
   assign sp_dn = cur_sp - ADDR_W'(1);

   always_comb begin
      next_sp   = cur_sp;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (act)
         STK_PUSH: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur_sp;
            mem_wdata = push_data;
            next_sp   = sp_dn;
         end
         STK_POP: begin
            mem_req  = 1'b1;
            mem_addr = sp_up;
            next_sp  = sp_up;
         end
         default: ;
      endcase
   end

   // R6: a write goes to the old SP and the stack then grows downward
   a_r6_write_then_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_addr == cur_sp && next_sp == mem_addr - ADDR_W'(1)));

   // R7: a read lands on the already incremented SP
   a_r7_inc_then_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (mem_addr == next_sp && next_sp - ADDR_W'(1) == cur_sp));

   // R5: without a request SP is left alone
   a_r5_sp_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req |-> next_sp == cur_sp);

endmodule

// File: rtl/flow_ctl_unit.sv
module flow_ctl_unit
   import flow_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LOC_W      = 24,
   parameter int LEN_W      = 2,
   parameter int COND_STYLE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        op_type,
   input  logic [ADDR_W-1:0] cur_ip,
   input  logic [ADDR_W-1:0] cur_sp,
   input  logic              flag_z,
   input  logic              flag_s,
   input  logic [LOC_W-1:0]  rel_loc,
   input  logic [DATA_W-1:0] opnd_val,
   input  logic [LEN_W-1:0]  instr_len,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] next_ip,
   output logic [ADDR_W-1:0] next_sp,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              halted
);

   if (LOC_W < 2 || LOC_W > ADDR_W) begin : g_bad_loc
      $error("flow_ctl_unit: LOC_W must lie in 2..ADDR_W");
   end
   if (LEN_W < 1 || LEN_W >= ADDR_W) begin : g_bad_len
      $error("flow_ctl_unit: LEN_W must lie in 1..ADDR_W-1");
   end
   if (DATA_W < ADDR_W) begin : g_bad_data
      $error("flow_ctl_unit: DATA_W must hold an address");
   end

   flow_ctl_t         ctl;
   logic              cond_hit;
   logic              taken;
   logic [ADDR_W-1:0] ret_ip;
   logic [DATA_W-1:0] ret_word;
   logic [DATA_W-1:0] push_data;
   logic              halted_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted_q <= 1'b0;
      end else if (op_type == OP_HALT) begin
         halted_q <= 1'b1;
      end
   end

   assign halted = halted_q;

   flow_op_class u_class (
      .op_type (op_type),
      .halted  (halted_q),
      .ctl     (ctl)
   );

   flow_cond_eval #(.COND_STYLE(COND_STYLE)) u_cond (
      .cond_code (op_type[2:0]),
      .flag_z    (flag_z),
      .flag_s    (flag_s),
      .taken     (cond_hit)
   );

   assign taken = ctl.is_cond ? cond_hit : 1'b1;

   flow_ip_sel #(.ADDR_W(ADDR_W), .LOC_W(LOC_W), .LEN_W(LEN_W)) u_ip (
      .clk        (clk),
      .rst_n      (rst_n),
      .tgt        (ctl.tgt),
      .taken      (taken),
      .cur_ip     (cur_ip),
      .rel_loc    (rel_loc),
      .instr_len  (instr_len),
      .abs_target (opnd_val[ADDR_W-1:0]),
      .mem_target (mem_rdata[ADDR_W-1:0]),
      .ret_ip     (ret_ip),
      .next_ip    (next_ip)
   );

   if (DATA_W > ADDR_W) begin : g_widen
      assign ret_word = {{(DATA_W-ADDR_W){1'b0}}, ret_ip};
   end else begin : g_same
      assign ret_word = ret_ip;
   end

   assign push_data = ctl.push_ret ? ret_word : opnd_val;

   flow_stack_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .act       (ctl.stk),
      .cur_sp    (cur_sp),
      .push_data (push_data),
      .next_sp   (next_sp),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );

   // R11: once set, halted stays set until reset
   a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   // R11: a halt operation raises halted at the following edge
   a_r11_halt_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (op_type == OP_HALT) |=> halted);

   // R11: while halted nothing moves and memory is left alone
   a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (next_ip == cur_ip && next_sp == cur_sp && !mem_req));

   // R9: a software interrupt writes a return address and goes to the operand
   a_r9_swi_target: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && op_type == OP_SWI) |-> (mem_we && next_ip == opnd_val[ADDR_W-1:0]));

endmodule

// File: tb/test_flow_ctl_unit.sv
`timescale 1ns/1ps
module test_flow_ctl_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  op_type = 8'hFF;
   logic [31:0] cur_ip = '0;
   logic [31:0] cur_sp = '0;
   logic        flag_z = 1'b0;
   logic        flag_s = 1'b0;
   logic [23:0] rel_loc = '0;
   logic [31:0] opnd_val = '0;
   logic [1:0]  instr_len = 2'd1;
   logic [31:0] mem_rdata = '0;
   logic [31:0] next_ip, next_sp, mem_addr, mem_wdata;
   logic        mem_req, mem_we, halted;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   bit m_halted = 1'b0;

   always #4 clk = ~clk;

   flow_ctl_unit i_flow_ctl_unit (
      .clk(clk), .rst_n(rst_n), .op_type(op_type), .cur_ip(cur_ip),
      .cur_sp(cur_sp), .flag_z(flag_z), .flag_s(flag_s), .rel_loc(rel_loc),
      .opnd_val(opnd_val), .instr_len(instr_len), .mem_rdata(mem_rdata),
      .next_ip(next_ip), .next_sp(next_sp), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .halted(halted)
   );

   // Behavioural reference for one cycle; compares every output.
   task automatic step(input logic [7:0] op, input logic [31:0] ip, input logic [31:0] sp,
                       input logic z, input logic s, input logic [23:0] loc,
                       input logic [31:0] val, input logic [1:0] len,
                       input logic [31:0] rd, input string tag);
      logic [31:0] e_ip, e_sp, e_addr, e_wdata, seq, off;
      logic e_req, e_we, go, bad;
      @(negedge clk);
      op_type = op; cur_ip = ip; cur_sp = sp; flag_z = z; flag_s = s;
      rel_loc = loc; opnd_val = val; instr_len = len; mem_rdata = rd;
      #2;
      seq = ip + 32'(len);
      off = {{8{loc[23]}}, loc};
      e_ip = seq; e_sp = sp; e_req = 0; e_we = 0; e_addr = 0; e_wdata = 0;
      if (m_halted || op == 8'hEE) begin
         e_ip = ip;
      end else begin
         case (op)
            8'h50: go = 1;
            8'h51: go = z;
            8'h52: go = !z;
            8'h53: go = s;
            8'h54: go = !s;
            8'h55: go = s || z;
            8'h56: go = !s && !z;
            default: go = 0;
         endcase
         if (op >= 8'h50 && op <= 8'h56 && go) e_ip = ip + off;
         if (op == 8'h60 || op == 8'h61) begin
            e_req = 1; e_we = 1; e_addr = sp; e_wdata = val; e_sp = sp - 1;
         end
         if (op == 8'h62) begin
            e_req = 1; e_addr = sp + 1; e_sp = sp + 1;
         end
         if (op == 8'h70 || op == 8'h72) begin
            e_req = 1; e_we = 1; e_addr = sp; e_wdata = seq; e_sp = sp - 1;
            e_ip = (op == 8'h70) ? ip + off : val;
         end
         if (op == 8'h71) begin
            e_req = 1; e_addr = sp + 1; e_sp = sp + 1; e_ip = rd;
         end
      end
      bad = (next_ip !== e_ip) || (next_sp !== e_sp) || (mem_req !== e_req) ||
            (halted !== m_halted) ||
            (e_req && ((mem_we !== e_we) || (mem_addr !== e_addr) ||
                       (e_we && mem_wdata !== e_wdata)));
      checks++;
      if (bad) begin
         errors++;
         $display("FAIL %s op=%h: actual ip=%h sp=%h req=%b we=%b addr=%h wd=%h halt=%b expected ip=%h sp=%h req=%b we=%b addr=%h wd=%h halt=%b",
                  tag, op, next_ip, next_sp, mem_req, mem_we, mem_addr, mem_wdata, halted,
                  e_ip, e_sp, e_req, e_we, e_addr, e_wdata, m_halted);
      end
      if (op == 8'hEE) m_halted = 1'b1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      op_type = 8'hFF;
      repeat (2) @(negedge clk);
      m_halted = 1'b0;
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset();
      // R1: reset state and normal following
      step(8'hFF, 32'h100, 32'hFFFF_FF00, 0, 0, 0, 0, 2'd1, 0, "R1");
      // R2: unconditional relative jumps
      step(8'h50, 32'h100, 32'h500, 0, 0, 24'd5, 0, 2'd1, 0, "R2");
      step(8'h50, 32'h100, 32'h500, 1, 1, 24'd0, 0, 2'd1, 0, "R2");
      step(8'h50, 32'h100, 32'h500, 0, 1, 24'hFFFFFD, 0, 2'd1, 0, "R2");
      step(8'h50, 32'h0080_0000, 32'h500, 0, 0, 24'h800000, 0, 2'd1, 0, "R2");
      // R3 and R4: every flag combination for each conditional type
      for (int c = 1; c <= 6; c++) begin
         for (int f = 0; f < 4; f++) begin
            step(8'h50 + 8'(c), 32'h2000, 32'h700, f[0], f[1], 24'd12, 0, 2'd1, 0,
                 (c <= 4) ? "R3" : "R4");
         end
      end
      // R5: non-control operations of several lengths
      step(8'h01, 32'h300, 32'h700, 0, 0, 24'd9, 32'h55, 2'd2, 0, "R5");
      step(8'h10, 32'h300, 32'h700, 1, 1, 24'd9, 32'h55, 2'd3, 0, "R5");
      step(8'hFF, 32'hFFFF_FFFF, 32'h700, 0, 0, 0, 0, 2'd1, 0, "R5");
      // R6: pushes, including wrap below zero
      step(8'h60, 32'h400, 32'h1000, 0, 0, 0, 32'hDEAD_BEEF, 2'd2, 0, "R6");
      step(8'h61, 32'h400, 32'h0, 0, 0, 0, 32'h1234_5678, 2'd1, 0, "R6");
      // R7: pops, including wrap past all-ones
      step(8'h62, 32'h400, 32'h0FFF, 0, 0, 0, 0, 2'd1, 0, "R7");
      step(8'h62, 32'h400, 32'hFFFF_FFFF, 0, 0, 0, 0, 2'd1, 0, "R7");
      // R8: calls forward and backward
      step(8'h70, 32'h800, 32'h1000, 0, 0, 24'd10, 0, 2'd1, 0, "R8");
      step(8'h70, 32'h800, 32'h0FFF, 1, 0, 24'hFFFFF0, 0, 2'd1, 0, "R8");
      // R9: software interrupt to an absolute target
      step(8'h72, 32'h900, 32'h1000, 0, 1, 24'd3, 32'h0000_2000, 2'd1, 0, "R9");
      // R10: return from the popped word
      step(8'h71, 32'h2000, 32'h0FFF, 0, 0, 24'd3, 0, 2'd1, 32'h0000_0901, "R10");
      // R11: halt, then attempts to move while halted
      step(8'hEE, 32'hA00, 32'h1000, 0, 0, 24'd4, 0, 2'd1, 0, "R11");
      step(8'h50, 32'hA00, 32'h1000, 0, 0, 24'd4, 0, 2'd1, 0, "R11");
      step(8'h60, 32'hA00, 32'h1000, 0, 0, 0, 32'h77, 2'd1, 0, "R11");
      step(8'h71, 32'hA00, 32'h1000, 0, 0, 0, 0, 2'd1, 32'h5, "R11");
      // R1: reset clears halt and operation resumes
      do_reset();
      step(8'h50, 32'hA00, 32'h1000, 0, 0, 24'd4, 0, 2'd1, 0, "R1");
      step(8'h62, 32'hA04, 32'h1000, 0, 0, 0, 0, 2'd1, 0, "R1");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule